// File: doc/BRIEF.md
# Integer ALU with Instruction Decode

This block is the execute stage for a small 32-bit load/store RISC core. It reads the raw 6-bit primary opcode and 6-bit function field of an instruction and decodes them itself. It takes the two register operands and the 16-bit immediate, widens the immediate in the way that instruction calls for, and computes the result. It also reports whether the result may be written back, whether the signed result overflowed, and whether the encoding is one it does not know.

Instructions enter through a valid/ready handshake and leave through a second one. The result sits in a single output register. An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, the output register holds its value. The stage then accepts no new instruction, because `in_ready` is low exactly when the output is full and not being drained. When the consumer drains the output, a new instruction can be taken in that same cycle. The register file, memory access, branches and multiply/divide live elsewhere.

Top module: `int_alu_core`

## Requirements
- R1: With opcode 0, the function code selects the register-register operation: 32 add, 34 subtract (a minus b), 36 AND, 37 OR, 38 XOR, 39 NOR. NOR of two zero operands gives all ones. For these operations `res_we` is 1 unless an overflow occurs.
- R2: Function code 42 with opcode 0 (register form), and opcode 10 (immediate form), produce exactly 1 when operand a is less than the second operand, and 0 otherwise. Both operands are compared as two's-complement signed values.
- R3: Opcode 8 adds operand a to the immediate sign-extended to 32 bits, so the immediate covers -32768..32767. Operand b has no effect.
- R4: Opcodes 12, 13 and 14 apply AND, OR and XOR between operand a and the immediate zero-extended to 32 bits. Operand b has no effect.
- R5: Opcode 15 returns the immediate in bits 31:16 and zeros in bits 15:0. Operands a and b have no effect.
- R6: Register add, register subtract and immediate add set `res_ovf` when the true signed result lies outside the 32-bit range. In that case `res_we` is 0 and `res_data` carries the wrapped value. No other operation sets `res_ovf`.
- R7: An opcode outside {0,8,10,12,13,14,15}, or opcode 0 with a function code outside {32,34,36,37,38,39,42}, gives `res_illegal`=1, `res_we`=0, `res_ovf`=0 and `res_data`=0.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A result accepted on one edge is presented on the following cycle, in acceptance order. While `out_valid` is high and `out_ready` is low, all outputs stay unchanged.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction fields and operands are present |
| in_ready | output | 1 | Stage can take an instruction this cycle |
| in_opcode | input | 6 | Primary opcode field |
| in_funct | input | 6 | Function field, used when the opcode is 0 |
| in_a | input | 32 | First register operand |
| in_b | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result register holds an undelivered result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 32 | Computed result |
| res_we | output | 1 | Result may be written back |
| res_ovf | output | 1 | Signed overflow on add, subtract or immediate add |
| res_illegal | output | 1 | Encoding not recognised |

## Verification
The bench builds the block with its default widths: a 32-bit datapath and a 16-bit immediate. These are the only widths for which the fixed opcode and function encodings and the signed range limits at 0x7FFFFFFF and 0x80000000 carry their intended meaning. At these widths the bench can reach both overflow boundaries, the -32768 immediate edge, and a zero-extended 0xFFFF immediate. Throughout the run the consumer applies irregular back-pressure, so stalls arrive both in isolation and back to back.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  // primary opcodes
  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI = 6'd14;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;

  // function codes under OPC_REG
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR, K_SLT, K_LUI
  } alu_kind_e;

  typedef enum logic [1:0] {
    BSRC_REG, BSRC_SEXT, BSRC_ZEXT
  } bsrc_e;

  typedef struct packed {
    alu_kind_e kind;
    bsrc_e     bsrc;
    logic      ill;
  } dec_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import int_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output dec_t             dec
);

  always_comb begin
    dec.kind = K_NONE;
    dec.bsrc = BSRC_REG;
    dec.ill  = 1'b0;
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_ADD:  dec.kind = K_ADD;
          FN_SUB:  dec.kind = K_SUB;
          FN_AND:  dec.kind = K_AND;
          FN_OR:   dec.kind = K_OR;
          FN_XOR:  dec.kind = K_XOR;
          FN_NOR:  dec.kind = K_NOR;
          FN_SLT:  dec.kind = K_SLT;
          default: dec.ill  = 1'b1;
        endcase
      end
      OPC_ADDI: begin dec.kind = K_ADD; dec.bsrc = BSRC_SEXT; end
      OPC_SLTI: begin dec.kind = K_SLT; dec.bsrc = BSRC_SEXT; end
      OPC_ANDI: begin dec.kind = K_AND; dec.bsrc = BSRC_ZEXT; end
      OPC_ORI:  begin dec.kind = K_OR;  dec.bsrc = BSRC_ZEXT; end
      OPC_XORI: begin dec.kind = K_XOR; dec.bsrc = BSRC_ZEXT; end
      OPC_LUI:  begin dec.kind = K_LUI; dec.bsrc = BSRC_ZEXT; end
      default:  dec.ill = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_operand.sv
module alu_operand
  import int_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  reg_b,
  input  logic [IMM_W-1:0] imm,
  input  bsrc_e            bsrc,
  output logic [XLEN-1:0]  opnd_b
);

  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_s;
  logic [XLEN-1:0] imm_z;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_s = {{PAD_W{imm[IMM_W-1]}}, imm};
      assign imm_z = {{PAD_W{1'b0}}, imm};
    end else begin : g_trunc
      assign imm_s = imm[XLEN-1:0];
      assign imm_z = imm[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    unique case (bsrc)
      BSRC_SEXT: opnd_b = imm_s;
      BSRC_ZEXT: opnd_b = imm_z;
      default:   opnd_b = reg_b;
    endcase
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import int_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  alu_kind_e        kind,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  result,
  output logic             ovf
);

  localparam int MSB   = XLEN - 1;
  localparam int LOW_W = XLEN - IMM_W;

  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] upper;
  logic            add_ovf;
  logic            sub_ovf;
  logic            lt;

  assign sum  = opnd_a + opnd_b;
  assign diff = opnd_a - opnd_b;

  // same-sign inputs whose sum flips sign
  assign add_ovf = (opnd_a[MSB] == opnd_b[MSB]) && (sum[MSB] != opnd_a[MSB]);
  // mixed-sign inputs whose difference takes the subtrahend's sign
  assign sub_ovf = (opnd_a[MSB] != opnd_b[MSB]) && (diff[MSB] != opnd_a[MSB]);
  assign lt      = $signed(opnd_a) < $signed(opnd_b);

  generate
    if (LOW_W > 0) begin : g_up
      assign upper = {imm, {LOW_W{1'b0}}};
    end else begin : g_up_trunc
      assign upper = imm[IMM_W-1 -: XLEN];
    end
  endgenerate

  always_comb begin
    unique case (kind)
      K_ADD:   result = sum;
      K_SUB:   result = diff;
      K_AND:   result = opnd_a & opnd_b;
      K_OR:    result = opnd_a | opnd_b;
      K_XOR:   result = opnd_a ^ opnd_b;
      K_NOR:   result = ~(opnd_a | opnd_b);
      K_SLT:   result = {{(XLEN-1){1'b0}}, lt};
      K_LUI:   result = upper;
      default: result = '0;
    endcase
  end

  always_comb begin
    unique case (kind)
      K_ADD:   ovf = add_ovf;
      K_SUB:   ovf = sub_ovf;
      default: ovf = 1'b0;
    endcase
  end

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
  import int_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [5:0]       in_opcode,
  input  logic [5:0]       in_funct,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  res_data,
  output logic             res_we,
  output logic             res_ovf,
  output logic             res_illegal
);

  dec_t            dec;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_res;
  logic            alu_ovf;
  logic            take;

  alu_decode u_dec (
    .opcode (in_opcode),
    .funct  (in_funct),
    .dec    (dec)
  );

  alu_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
    .reg_b  (in_b),
    .imm    (in_imm),
    .bsrc   (dec.bsrc),
    .opnd_b (opnd_b)
  );

  alu_exec #(.XLEN(XLEN), .IMM_W(IMM_W)) u_exec (
    .kind   (dec.kind),
    .opnd_a (in_a),
    .opnd_b (opnd_b),
    .imm    (in_imm),
    .result (alu_res),
    .ovf    (alu_ovf)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      res_data    <= '0;
      res_we      <= 1'b0;
      res_ovf     <= 1'b0;
      res_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      res_data    <= alu_res;
      res_we      <= !dec.ill && !alu_ovf;
      res_ovf     <= alu_ovf;
      res_illegal <= dec.ill;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] res_data,
  input logic            res_we,
  input logic            res_ovf,
  input logic            res_illegal
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_data) && $stable(res_we)
                                && $stable(res_ovf) && $stable(res_illegal));

  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8
  fill_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

  // R6
  ovf_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_ovf |-> !res_we && !res_illegal);

  // R7
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_illegal |-> !res_we && !res_ovf && (res_data == '0));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({res_we, res_ovf, res_illegal}));

endmodule

bind int_alu_core alu_core_chk #(.XLEN(XLEN)) u_alu_core_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .res_data    (res_data),
  .res_we      (res_we),
  .res_ovf     (res_ovf),
  .res_illegal (res_illegal)
);

// File: tb/test_int_alu_core.sv
module test_int_alu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_opcode = '0;
  logic [5:0]  in_funct = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] res_data;
  logic        res_we;
  logic        res_ovf;
  logic        res_illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] d;
    logic        we;
    logic        ovf;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t q[$];
  bit   stalled = 1'b0;

  always #10 clk = ~clk;

  int_alu_core i_int_alu_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_funct(in_funct), .in_a(in_a), .in_b(in_b),
    .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready),
    .res_data(res_data), .res_we(res_we), .res_ovf(res_ovf),
    .res_illegal(res_illegal)
  );

  function automatic exp_t model(logic [5:0] opc, logic [5:0] fn,
                                 logic [31:0] a, logic [31:0] b, logic [15:0] imm);
    exp_t   e;
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint si = longint'($signed(imm));
    longint s  = 0;
    bit     arith = 0;
    e.d = 0; e.we = 1; e.ovf = 0; e.ill = 0; e.tag = "R1";
    case (opc)
      6'd0: case (fn)
        6'd32: begin s = sa + sb; arith = 1; end
        6'd34: begin s = sa - sb; arith = 1; end
        6'd36: e.d = a & b;
        6'd37: e.d = a | b;
        6'd38: e.d = a ^ b;
        6'd39: e.d = ~(a | b);
        6'd42: begin e.d = (sa < sb) ? 32'd1 : 32'd0; e.tag = "R2"; end
        default: e.ill = 1;
      endcase
      6'd8:  begin s = sa + si; arith = 1; e.tag = "R3"; end
      6'd10: begin e.d = (sa < si) ? 32'd1 : 32'd0; e.tag = "R2"; end
      6'd12: begin e.d = a & {16'h0, imm}; e.tag = "R4"; end
      6'd13: begin e.d = a | {16'h0, imm}; e.tag = "R4"; end
      6'd14: begin e.d = a ^ {16'h0, imm}; e.tag = "R4"; end
      6'd15: begin e.d = {imm, 16'h0}; e.tag = "R5"; end
      default: e.ill = 1;
    endcase
    if (arith) begin
      e.d = s[31:0];
      if (s > 64'sd2147483647 || s < -64'sd2147483648) begin
        e.ovf = 1; e.we = 0; e.tag = "R6";
      end
    end
    if (e.ill) begin
      e.d = 0; e.we = 0; e.ovf = 0; e.tag = "R7";
    end
    return e;
  endfunction

  // called once per cycle after drives settle, before the next rising edge
  task automatic observe(output bit accepted);
    exp_t e;
    accepted = 1'b0;
    if (stalled) begin
      total++;
      if (!out_valid) begin
        bad++;
        $display("FAIL R8 stalled result dropped: out_valid=%0b expected=1", out_valid);
      end
    end
    if (out_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected result: data=%h expected none", res_data);
      end else begin
        e = q[0];
        if (res_data !== e.d || res_we !== e.we || res_ovf !== e.ovf || res_illegal !== e.ill) begin
          bad++;
          $display("FAIL %s actual d=%h we=%0b ovf=%0b ill=%0b expected d=%h we=%0b ovf=%0b ill=%0b",
                   e.tag, res_data, res_we, res_ovf, res_illegal, e.d, e.we, e.ovf, e.ill);
        end
      end
      total++;
      if (in_ready !== out_ready) begin
        bad++;
        $display("FAIL R8 in_ready=%0b expected=%0b", in_ready, out_ready);
      end
    end
    stalled = out_valid && !out_ready;
    if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
    if (in_valid && in_ready) begin
      q.push_back(model(in_opcode, in_funct, in_a, in_b, in_imm));
      accepted = 1'b1;
    end
  endtask

  task automatic send(logic [5:0] opc, logic [5:0] fn, logic [31:0] a,
                      logic [31:0] b, logic [15:0] imm);
    bit acc;
    do begin
      @(negedge clk);
      in_valid = 1'b1; in_opcode = opc; in_funct = fn;
      in_a = a; in_b = b; in_imm = imm;
      out_ready = ($urandom % 3) != 0;
      #1;
      observe(acc);
    end while (!acc);
  endtask

  task automatic idle(bit rdy);
    bit acc;
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = rdy;
    #1;
    observe(acc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    total++;
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R9 out_valid=%0b expected=0", out_valid);
    end
    total++;
    if (in_ready !== 1'b1) begin
      bad++; $display("FAIL R9 in_ready=%0b expected=1", in_ready);
    end

    // R1 register forms
    send(6'd0, 6'd32, 32'd1000, 32'd234, 16'h0);
    send(6'd0, 6'd34, 32'd5, 32'd9, 16'h0);
    send(6'd0, 6'd36, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0);
    send(6'd0, 6'd37, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0);
    send(6'd0, 6'd38, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0);
    send(6'd0, 6'd39, 32'h0, 32'h0, 16'h0);
    // R2 signed compare
    send(6'd0, 6'd42, 32'hFFFF_FFFF, 32'd1, 16'h0);
    send(6'd0, 6'd42, 32'd1, 32'hFFFF_FFFF, 16'h0);
    send(6'd10, 6'd0, 32'hFFFF_0000, 32'h0, 16'h8000);
    send(6'd10, 6'd0, 32'hFFFF_8000, 32'h0, 16'h8000);
    // R3 sign-extended add, b ignored
    send(6'd8, 6'd0, 32'd100, 32'hDEAD_BEEF, 16'hFFFF);
    send(6'd8, 6'd0, 32'd0, 32'h1234_5678, 16'h8000);
    // R4 zero-extended logic, b ignored
    send(6'd12, 6'd0, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 16'hFFFF);
    send(6'd13, 6'd0, 32'h1234_0000, 32'hAAAA_AAAA, 16'h8001);
    send(6'd14, 6'd0, 32'hFFFF_FFFF, 32'h0, 16'h00FF);
    // R5 upper immediate, a and b ignored
    send(6'd15, 6'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h2110);
    // R6 overflow edges
    send(6'd0, 6'd32, 32'h7FFF_FFFF, 32'd1, 16'h0);
    send(6'd0, 6'd34, 32'h8000_0000, 32'd1, 16'h0);
    send(6'd8, 6'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001);
    send(6'd8, 6'd0, 32'h8000_0000, 32'h0, 16'hFFFF);
    send(6'd0, 6'd32, 32'h8000_0000, 32'h8000_0000, 16'h0);
    // R7 unknown encodings
    send(6'd63, 6'd32, 32'h1, 32'h2, 16'h3);
    send(6'd0, 6'd33, 32'h1, 32'h2, 16'h3);
    send(6'd9, 6'd0, 32'h1, 32'h2, 16'h3);

    // R8 mixed traffic with back-pressure and gaps
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [5:0] opc;
      logic [5:0] fn;
      r = $urandom % 18;
      fn = 6'($urandom);
      case (r)
        0, 1, 2, 3, 4, 5, 6: begin
          opc = 6'd0;
          case (r)
            0: fn = 6'd32; 1: fn = 6'd34; 2: fn = 6'd36; 3: fn = 6'd37;
            4: fn = 6'd38; 5: fn = 6'd39; default: fn = 6'd42;
          endcase
        end
        7: opc = 6'd8;  8: opc = 6'd10; 9: opc = 6'd12;
        10: opc = 6'd13; 11: opc = 6'd14; 12: opc = 6'd15;
        13: opc = 6'd0;
        default: opc = 6'($urandom);
      endcase
      if (($urandom % 4) == 0) idle(($urandom % 2) == 0);
      send(opc, fn, $urandom, $urandom, 16'($urandom));
    end

    // drain
    for (int k = 0; k < 20; k++) idle(1'b1);
    total++;
    if (q.size() != 0 || out_valid) begin
      bad++;
      $display("FAIL R8 pending=%0d out_valid=%0b expected 0 and 0", q.size(), out_valid);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule